// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner

This block sits between the raw clock and data pins of a two-wire serial slave and its protocol engine. Each line is brought into the system clock domain through a flop chain and then passed through a persistence filter: a new level is accepted only when the synchronised input has held it for a programmable number of consecutive system-clock samples. Shorter pulses are discarded, which covers the 50 ns spike rejection the bus demands.

From the two clean levels the block derives one-cycle strobes for bus start, bus stop, clock rising edge and clock falling edge. It also tracks whether a transfer is in progress. The protocol engine reads these strobes instead of sampling the pins itself.

On the way out, the engine's request to pull the data line low passes through a hold stage. A new request takes effect only while the clock is low, and only once a minimum number of cycles has passed since the last clock fall. The slave's own transmitted bits therefore never move the data line near a clock edge, where another device could mistake them for a start or a stop.

Top module: `tw_bus_cond`

## Requirements
- R1: While reset is asserted and right after it, `scl_lvl` and `sda_lvl` are 1, all four strobes are 0, `bus_busy` is 0 and `sda_pull` is 0.
- R2: A raw level that holds for at least FILT_CYC cycles appears on its filtered output exactly SYNC_STAGES+FILT_CYC cycles after the first rising edge that samples it. With the defaults of 2 and 4, it appears on the 6th edge.
- R3: A raw pulse that lasts fewer than FILT_CYC cycles causes no change on `scl_lvl` or `sda_lvl` and produces no strobe.
- R4: `start_stb` is high for exactly one cycle, in the first cycle in which `sda_lvl` reads 0 after reading 1, while `scl_lvl` is 1 in both that cycle and the one before it.
- R5: `stop_stb` is high for exactly one cycle, in the first cycle in which `sda_lvl` reads 1 after reading 0, while `scl_lvl` is 1 in both that cycle and the one before it.
- R6: `scl_rise_stb` (or `scl_fall_stb`) is high only in the first cycle of a new high (or low) level on `scl_lvl`.
- R7: `start_stb` and `stop_stb` are never high in the same cycle. Every change of `sda_lvl` while `scl_lvl` stays high raises one of the two.
- R8: `bus_busy` becomes 1 in the cycle after a start strobe and 0 in the cycle after a stop strobe. A repeated start leaves it at 1.
- R9: `sda_pull` changes only while `scl_lvl` is 0, and never earlier than HOLD_CYC cycles after a clock fall. When a request is already pending at the fall, the change is visible HOLD_CYC+2 cycles after the cycle in which `scl_fall_stb` is high.
- R10: A change of `tx_sda_low` while `scl_lvl` is 1 has no effect on `sda_pull` until the clock has fallen and the hold interval has passed.
- R11: While `scl_lvl` is 0 and the hold interval has already expired, `sda_pull` follows `tx_sda_low` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| tx_sda_low | input | 1 | Engine request: 1 pulls the data line low |
| scl_lvl | output | 1 | Filtered clock level |
| sda_lvl | output | 1 | Filtered data level |
| start_stb | output | 1 | One-cycle start condition strobe |
| stop_stb | output | 1 | One-cycle stop condition strobe |
| scl_rise_stb | output | 1 | One-cycle clock rising strobe |
| scl_fall_stb | output | 1 | One-cycle clock falling strobe |
| bus_busy | output | 1 | Transfer in progress (between start and stop) |
| sda_pull | output | 1 | Hold-delayed data drive; 1 pulls the line low |

## Verification
The lines are exercised with full bit frames in which data changes only while the clock is low, with start, stop and repeated start patterns, and with short spikes on each line. These patterns separate real conditions from data traffic and from noise. A pulse of exactly FILT_CYC cycles is placed next to one of FILT_CYC-1 cycles, which pins the filter threshold to a single cycle. The output hold is measured cycle by cycle from the clock fall. Requests raised while the clock is high and requests raised after the hold has expired show that the gate depends both on the clock level and on the timer.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;

   // Level both bus lines rest at when nothing drives them
   localparam logic LINE_IDLE = 1'b1;

   // Event strobes derived from the filtered lines
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } tw_evt_t;

   // Index of each line inside the conditioning array
   localparam int IDX_SCL = 0;
   localparam int IDX_SDA = 1;
   localparam int N_LINES = 2;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_glitch_filt.sv
module tw_glitch_filt #(
   parameter int   FILT_CYC = 4,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (FILT_CYC <= 1) begin : g_pass
         // window of one sample: a plain register
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYC);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
         logic [CW-1:0] run;

         // count consecutive samples that differ from the held level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= RST_VAL;
               run <= '0;
            end else if (d == q) begin
               run <= '0;
            end else if (run == LAST) begin
               q   <= d;
               run <= '0;
            end else begin
               run <= run + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
   import tw_cond_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output tw_evt_t evt,
   output logic    busy
);
   logic scl_p;
   logic sda_p;
   logic scl_held_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= LINE_IDLE;
         sda_p <= LINE_IDLE;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   // clock high now and one cycle ago: any data move is a condition
   assign scl_held_hi = scl_f & scl_p;

   always_comb begin
      evt.start = scl_held_hi &  sda_p & ~sda_f;
      evt.stop  = scl_held_hi & ~sda_p &  sda_f;
      evt.rise  =  scl_f & ~scl_p;
      evt.fall  = ~scl_f &  scl_p;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (evt.start) busy <= 1'b1;
      else if (evt.stop)  busy <= 1'b0;
   end
endmodule

// File: rtl/tw_hold_timer.sv
module tw_hold_timer #(
   parameter int HOLD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic scl_fall,
   input  logic tx_req,
   output logic pull
);
   localparam int TW = $clog2(HOLD_CYC + 1);
   localparam logic [TW-1:0] LOAD = TW'(HOLD_CYC);

   logic [TW-1:0] tmr;
   logic          open_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tmr <= '0;
      else if (scl_fall)   tmr <= LOAD;
      else if (tmr != '0)  tmr <= tmr - TW'(1);
   end

   // drive may move only with the clock low and the hold spent
   assign open_win = ~scl_lvl & ~scl_fall & (tmr == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pull <= 1'b0;
      else if (open_win) pull <= tx_req;
   end
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond
   import tw_cond_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 4,
   parameter int HOLD_CYC    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic tx_sda_low,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic start_stb,
   output logic stop_stb,
   output logic scl_rise_stb,
   output logic scl_fall_stb,
   output logic bus_busy,
   output logic sda_pull
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_bus_cond: SYNC_STAGES must be at least 2");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("tw_bus_cond: FILT_CYC must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("tw_bus_cond: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic [N_LINES-1:0] raw;
   logic [N_LINES-1:0] synced;
   logic [N_LINES-1:0] filt;
   logic               scl_s;
   logic               sda_s;
   tw_evt_t            evt;

   assign raw[IDX_SCL] = scl_in;
   assign raw[IDX_SDA] = sda_in;

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         tw_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (LINE_IDLE)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[i]),
            .q     (synced[i])
         );

         tw_glitch_filt #(
            .FILT_CYC (FILT_CYC),
            .RST_VAL  (LINE_IDLE)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (synced[i]),
            .q     (filt[i])
         );
      end
   endgenerate

   assign scl_s   = synced[IDX_SCL];
   assign sda_s   = synced[IDX_SDA];
   assign scl_lvl = filt[IDX_SCL];
   assign sda_lvl = filt[IDX_SDA];

   tw_cond_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (scl_lvl),
      .sda_f (sda_lvl),
      .evt   (evt),
      .busy  (bus_busy)
   );

   assign start_stb    = evt.start;
   assign stop_stb     = evt.stop;
   assign scl_rise_stb = evt.rise;
   assign scl_fall_stb = evt.fall;

   tw_hold_timer #(
      .HOLD_CYC (HOLD_CYC)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (scl_lvl),
      .scl_fall (scl_fall_stb),
      .tx_req   (tx_sda_low),
      .pull     (sda_pull)
   );
endmodule

// File: rtl/tw_bus_cond_chk.sv
module tw_bus_cond_chk #(
   parameter int FILT_CYC = 4,
   parameter int HOLD_CYC = 16
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_s,
   input logic scl_lvl,
   input logic sda_lvl,
   input logic start_stb,
   input logic stop_stb,
   input logic scl_rise_stb,
   input logic scl_fall_stb,
   input logic bus_busy,
   input logic sda_pull
);
   localparam int SW   = $clog2(FILT_CYC + 1);
   localparam int FW   = $clog2(HOLD_CYC + 2);
   localparam logic [SW-1:0] SMAX = SW'(FILT_CYC);
   localparam logic [FW-1:0] FMAX = FW'(HOLD_CYC + 1);

   logic          scl_d, sda_d;
   logic [SW-1:0] scl_run, sda_run;
   logic [FW-1:0] since_fall;

   // how long each synchronised line has stayed unchanged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d   <= 1'b1;
         sda_d   <= 1'b1;
         scl_run <= SMAX;
         sda_run <= SMAX;
      end else begin
         scl_d   <= scl_s;
         sda_d   <= sda_s;
         scl_run <= (scl_s != scl_d) ? '0 : ((scl_run == SMAX) ? scl_run : scl_run + SW'(1));
         sda_run <= (sda_s != sda_d) ? '0 : ((sda_run == SMAX) ? sda_run : sda_run + SW'(1));
      end
   end

   // cycles since the last clock fall strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_fall <= FMAX;
      else if (scl_fall_stb)    since_fall <= FW'(1);
      else if (since_fall != FMAX) since_fall <= since_fall + FW'(1);
   end

   p_scl_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl != $past(scl_lvl)) |-> (scl_lvl == $past(scl_s) && int'(scl_run) >= FILT_CYC - 1));

   p_sda_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_lvl != $past(sda_lvl)) |-> (sda_lvl == $past(sda_s) && int'(sda_run) >= FILT_CYC - 1));

   p_start_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |-> (scl_lvl && $past(scl_lvl) && !sda_lvl && $past(sda_lvl)));

   p_stop_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |-> (scl_lvl && $past(scl_lvl) && sda_lvl && !$past(sda_lvl)));

   p_scl_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl != $past(scl_lvl)) |-> (scl_rise_stb == scl_lvl && scl_fall_stb == !scl_lvl));

   p_scl_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_rise_stb || scl_fall_stb) |-> (scl_lvl != $past(scl_lvl)));

   p_cond_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_stb, stop_stb}));

   p_cond_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && sda_lvl != $past(sda_lvl)) |-> (start_stb || stop_stb));

   p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |=> bus_busy);

   p_busy_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> !bus_busy);

   p_pull_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> (!$past(scl_lvl) && int'($past(since_fall)) >= HOLD_CYC));

   p_pull_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_lvl) && scl_lvl) |-> $stable(sda_pull));
endmodule

bind tw_bus_cond tw_bus_cond_chk #(
   .FILT_CYC (FILT_CYC),
   .HOLD_CYC (HOLD_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_s        (scl_s),
   .sda_s        (sda_s),
   .scl_lvl      (scl_lvl),
   .sda_lvl      (sda_lvl),
   .start_stb    (start_stb),
   .stop_stb     (stop_stb),
   .scl_rise_stb (scl_rise_stb),
   .scl_fall_stb (scl_fall_stb),
   .bus_busy     (bus_busy),
   .sda_pull     (sda_pull)
);

// File: tb/sim_tw_bus_cond.sv
module sim_tw_bus_cond;
   localparam int SYNC = 2;
   localparam int FILT = 4;
   localparam int HOLD = 16;
   localparam int NVEC = 21;

   typedef struct packed {
      logic       scl;
      logic       sda;
      logic [7:0] len;
      logic       es;
      logic       ed;
      logic [1:0] nst;
      logic [1:0] nsp;
      logic [1:0] nri;
      logic [1:0] nfa;
      logic       busy;
   } vec_t;

   function automatic vec_t mk(input int scl, input int sda, input int len,
                               input int es, input int ed, input int nst,
                               input int nsp, input int nri, input int nfa,
                               input int busy);
      vec_t v;
      v.scl  = 1'(scl);
      v.sda  = 1'(sda);
      v.len  = 8'(len);
      v.es   = 1'(es);
      v.ed   = 1'(ed);
      v.nst  = 2'(nst);
      v.nsp  = 2'(nsp);
      v.nri  = 2'(nri);
      v.nfa  = 2'(nfa);
      v.busy = 1'(busy);
      return v;
   endfunction

   //  raw scl/sda, cycles held, expected levels, start/stop/rise/fall counts, busy
   localparam vec_t TBL [NVEC] = '{
      mk(1,1,20, 1,1, 0,0,0,0, 0),   // idle
      mk(1,0,20, 1,0, 1,0,0,0, 1),   // start
      mk(0,0,20, 0,0, 0,0,0,1, 1),   // clock low
      mk(0,1,20, 0,1, 0,0,0,0, 1),   // data moves under low clock
      mk(1,1,20, 1,1, 0,0,1,0, 1),   // clock high
      mk(1,0,3,  1,1, 0,0,0,0, 1),   // data spike, FILT-1 long
      mk(1,1,20, 1,1, 0,0,0,0, 1),
      mk(0,1,20, 0,1, 0,0,0,1, 1),
      mk(0,0,20, 0,0, 0,0,0,0, 1),
      mk(1,0,20, 1,0, 0,0,1,0, 1),
      mk(1,1,20, 1,1, 0,1,0,0, 0),   // stop
      mk(0,1,2,  1,1, 0,0,0,0, 0),   // clock spike
      mk(1,1,20, 1,1, 0,0,0,0, 0),
      mk(1,0,4,  1,1, 0,0,0,0, 0),   // data pulse exactly FILT long
      mk(1,1,20, 1,1, 1,1,0,0, 0),   // its start and stop show here
      mk(1,0,20, 1,0, 1,0,0,0, 1),   // start
      mk(0,0,20, 0,0, 0,0,0,1, 1),
      mk(0,1,20, 0,1, 0,0,0,0, 1),
      mk(1,1,20, 1,1, 0,0,1,0, 1),
      mk(1,0,20, 1,0, 1,0,0,0, 1),   // repeated start
      mk(0,0,20, 0,0, 0,0,0,1, 1)
   };

   logic clk = 1'b0;
   logic rst_n;
   logic scl_in, sda_in, tx_sda_low;
   logic scl_lvl, sda_lvl, start_stb, stop_stb, scl_rise_stb, scl_fall_stb;
   logic bus_busy, sda_pull;

   always #10 clk = ~clk;

   tw_bus_cond #(
      .SYNC_STAGES (SYNC),
      .FILT_CYC    (FILT),
      .HOLD_CYC    (HOLD)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (scl_in),
      .sda_in       (sda_in),
      .tx_sda_low   (tx_sda_low),
      .scl_lvl      (scl_lvl),
      .sda_lvl      (sda_lvl),
      .start_stb    (start_stb),
      .stop_stb     (stop_stb),
      .scl_rise_stb (scl_rise_stb),
      .scl_fall_stb (scl_fall_stb),
      .bus_busy     (bus_busy),
      .sda_pull     (sda_pull)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int both   = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && start_stb && stop_stb) both++;
   end

   task automatic run_step(input vec_t v, input int idx);
      int st = 0;
      int sp = 0;
      int ri = 0;
      int fa = 0;
      string lt;
      scl_in = v.scl;
      sda_in = v.sda;
      for (int c = 0; c < int'(v.len); c++) begin
         tick();
         st += int'(start_stb);
         sp += int'(stop_stb);
         ri += int'(scl_rise_stb);
         fa += int'(scl_fall_stb);
      end
      lt = (int'(v.len) < FILT) ? "R3" : "R2";
      check(lt,   $sformatf("step %0d scl_lvl", idx), int'(scl_lvl), int'(v.es));
      check(lt,   $sformatf("step %0d sda_lvl", idx), int'(sda_lvl), int'(v.ed));
      check("R4", $sformatf("step %0d starts", idx), st, int'(v.nst));
      check("R5", $sformatf("step %0d stops", idx), sp, int'(v.nsp));
      check("R6", $sformatf("step %0d rises", idx), ri, int'(v.nri));
      check("R6", $sformatf("step %0d falls", idx), fa, int'(v.nfa));
      check("R8", $sformatf("step %0d busy", idx), int'(bus_busy), int'(v.busy));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n      = 1'b0;
      scl_in     = 1'b1;
      sda_in     = 1'b1;
      tx_sda_low = 1'b0;
      repeat (3) tick();
      // R1: state during reset
      check("R1", "scl_lvl in reset", int'(scl_lvl), 1);
      check("R1", "sda_lvl in reset", int'(sda_lvl), 1);
      check("R1", "strobes in reset",
            int'({start_stb, stop_stb, scl_rise_stb, scl_fall_stb}), 0);
      check("R1", "busy in reset", int'(bus_busy), 0);
      check("R1", "pull in reset", int'(sda_pull), 0);
      rst_n = 1'b1;
      tick();
      check("R1", "pull after reset", int'(sda_pull), 0);
      check("R1", "busy after reset", int'(bus_busy), 0);

      for (int i = 0; i < NVEC; i++) run_step(TBL[i], i);

      // R10: request raised with the clock high is deferred
      scl_in = 1'b1;
      repeat (20) tick();
      tx_sda_low = 1'b1;
      repeat (30) tick();
      check("R10", "pull while clock high", int'(sda_pull), 0);

      // R2 latency and R6 fall strobe, counted edge by edge
      scl_in = 1'b0;
      for (int k = 1; k <= SYNC + FILT; k++) begin
         tick();
         if (k == SYNC + FILT - 1) check("R2", "scl_lvl one edge early", int'(scl_lvl), 1);
         if (k == SYNC + FILT) begin
            check("R2", "scl_lvl on time", int'(scl_lvl), 0);
            check("R6", "fall strobe on time", int'(scl_fall_stb), 1);
         end
      end

      // R9: hold interval measured from the fall strobe cycle
      for (int j = 1; j <= HOLD + 2; j++) begin
         tick();
         if (j == HOLD + 1) check("R9", "pull one cycle early", int'(sda_pull), 0);
         if (j == HOLD + 2) check("R9", "pull after hold", int'(sda_pull), 1);
      end

      // R11: hold spent, clock low: follows in one cycle
      tx_sda_low = 1'b0;
      tick();
      check("R11", "release follows", int'(sda_pull), 0);
      tx_sda_low = 1'b1;
      tick();
      check("R11", "pull follows", int'(sda_pull), 1);

      // R10: release requested with the clock high is ignored
      scl_in = 1'b1;
      repeat (20) tick();
      tx_sda_low = 1'b0;
      repeat (10) tick();
      check("R10", "pull held while clock high", int'(sda_pull), 1);

      check("R7", "cycles with start and stop together", both, 0);
      finish_run();
   end
endmodule